// File: doc/BRIEF.md
# Display command stream register decoder

This block sits on the receive side of a display controller and turns a stream of command bytes into the contents of a bank of 8-bit control registers. Bytes arrive one per cycle on a valid/ready interface, and the block always accepts them. Each command begins with the lead byte 0xAF, and the byte after it is the opcode. The register-write opcode 0x20 is followed by one address byte and one data byte. The copy opcode 0x6A is followed by seven operand bytes: a 3-byte source, a 1-byte pixel count and a 3-byte destination. The decoder reads past all of them and changes no register.

A write to the reserved address 0xFF does not touch the bank. Instead it opens or closes a staging window. While the window is open, writes go only to a shadow bank, and the display side keeps seeing the old settings. When the window closes, the whole shadow bank is copied into the active bank in a single clock, and a one-cycle commit strobe tells the display logic that a new, consistent set of values is in place. This prevents a half-updated timing set from ever reaching the display.

The bank holds plain bytes, and the meaning of each address is left to the display logic. Those consumers use the layout below. The 24-bit base pointers of the two pixel-depth segments sit at 0x20..0x22 and 0x26..0x28, most significant byte first. 16-bit timing values use two consecutive addresses with the high byte at the lower address. The pixel clock, counted in 5 kHz steps, is the exception: it sits at 0x1B/0x1C with the low byte first.

Top module: `cmd_reg_decoder`

## Requirements
- R1: During and right after reset, every register reads zero and the commit strobe is low. The decoder leaves reset in the unlocked state and waiting for a lead byte.
- R2: While the decoder waits for a command start, any byte other than 0xAF is dropped and has no effect. It keeps searching until a 0xAF arrives.
- R3: The command 0xAF, 0x20, addr, data with the decoder unlocked and addr below REG_COUNT puts data at register addr. The new value shows on `regs_o` bits [8*addr+7:8*addr] in the cycle after the data byte is accepted.
- R4: Writing data 0x00 to address 0xFF locks the bank. While locked, register writes update only the shadow bank, and `regs_o` does not change.
- R5: Writing data 0xFF to address 0xFF unlocks the bank. In the cycle after the data byte, `regs_o` equals the full shadow bank, and `commit_o` is high for exactly that one cycle.
- R6: After the opcode 0x6A, the next seven accepted bytes are consumed with no register change, even if they contain 0xAF or 0x20. The byte after them is treated as a possible lead byte.
- R7: An opcode other than 0x20 or 0x6A is discarded, and the decoder goes back to waiting for a lead byte. The next byte is examined as a possible lead byte.
- R8: A write to an address at or above REG_COUNT other than 0xFF changes nothing. A write to 0xFF with data other than 0x00 or 0xFF also changes nothing, and it leaves the lock state as it was.
- R9: A cycle with `in_valid` low does not advance the parser. No register changes in that cycle, and no commit strobe results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A command byte is present on in_data |
| in_data | input | 8 | Command stream byte |
| in_ready | output | 1 | Byte accepted; always high |
| regs_o | output | 8*REG_COUNT | Active register bank, register n at bits [8n+7:8n] |
| commit_o | output | 1 | One-cycle pulse after the bank is unlocked |

## Verification
A parser that has lost its place in the stream shows up the next time a write lands. Either a register picks up an operand byte, or an intended write goes missing, and `regs_o` differs from the model one cycle after that data byte. A lock flag that is wrong shows in one of two ways. Locked writes leak onto `regs_o` at once, or unlocked writes stay invisible until the next commit. A shadow bank that is wrong stays hidden until the unlock, when the whole bank is compared in the cycle the strobe rises.

// File: rtl/cmd_reg_decoder.sv
module cmd_reg_decoder #(
  parameter int REG_COUNT = 64,
  parameter logic [7:0] LEAD_BYTE = 8'hAF,
  parameter logic [7:0] OP_WRITE = 8'h20,
  parameter logic [7:0] OP_COPY = 8'h6A,
  parameter logic [7:0] LOCK_ADDR = 8'hFF,
  parameter int COPY_TAIL = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  output logic                   in_ready,
  output logic [8*REG_COUNT-1:0] regs_o,
  output logic                   commit_o
);
  localparam int CW = $clog2(COPY_TAIL + 1);
  localparam logic [2:0] S_HUNT = 3'd0, S_OPC = 3'd1, S_ADDR = 3'd2,
                         S_DATA = 3'd3, S_SKIP = 3'd4;

  logic [2:0]    st_q;
  logic [7:0]    addr_q;
  logic [CW-1:0] cnt_q;
  logic          locked_q;
  logic [7:0]    shadow [REG_COUNT];
  logic [7:0]    active [REG_COUNT];

  wire wr_fire   = in_valid && (st_q == S_DATA);
  wire bank_hit  = wr_fire && ({24'd0, addr_q} < REG_COUNT);
  wire ctl_hit   = wr_fire && (addr_q == LOCK_ADDR);
  wire lock_go   = ctl_hit && (in_data == 8'h00);
  wire unlock_go = ctl_hit && (in_data == 8'hFF);

  assign in_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_HUNT;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (in_valid) begin
      case (st_q)
        S_HUNT: if (in_data == LEAD_BYTE) st_q <= S_OPC;
        S_OPC: begin
          cnt_q <= '0;
          if (in_data == OP_WRITE) st_q <= S_ADDR;
          else if (in_data == OP_COPY) st_q <= S_SKIP;
          else st_q <= S_HUNT;
        end
        S_ADDR: begin
          addr_q <= in_data;
          st_q   <= S_DATA;
        end
        S_DATA: st_q <= S_HUNT;
        S_SKIP: begin
          if (cnt_q == CW'(COPY_TAIL - 1)) st_q <= S_HUNT;
          cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= unlock_go;
      if (lock_go) locked_q <= 1'b1;
      else if (unlock_go) locked_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    wire sel = bank_hit && (addr_q == 8'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end else begin
        if (sel) shadow[i] <= in_data;
        if (unlock_go) active[i] <= shadow[i];
        else if (sel && !locked_q) active[i] <= in_data;
      end
    end
    assign regs_o[8*i +: 8] = active[i];
  end
endmodule

module cmd_reg_decoder_chk #(
  parameter int REG_COUNT = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [8*REG_COUNT-1:0] regs_o,
  input logic                   commit_o,
  input logic                   locked,
  input logic                   skipping
);
  a_r1_reset_clean: assert property (@(posedge clk)
    $rose(rst_n) |-> (regs_o == '0 && !commit_o));

  a_r5_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  a_r4_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(regs_o));

  a_r6_copy_inert: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |=> $stable(regs_o));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(regs_o) && !commit_o));
endmodule

bind cmd_reg_decoder cmd_reg_decoder_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .regs_o(regs_o),
  .commit_o(commit_o), .locked(locked_q), .skipping(st_q == 3'd4)
);

// File: tb/cmd_reg_decoder_test.sv
module cmd_reg_decoder_test;
  localparam int N = 64;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, commit_o;
  logic [8*N-1:0] regs_o;

  cmd_reg_decoder #(.REG_COUNT(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .regs_o(regs_o), .commit_o(commit_o));

  always #5 clk = ~clk;

  int vecs = 0, bad = 0;
  string req = "R1";
  int m_sh[N], m_act[N];
  int m_st, m_addr, m_cnt;
  bit m_lock, m_commit;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    m_st = 0; m_addr = 0; m_cnt = 0; m_lock = 0; m_commit = 0;
  endtask

  task automatic model_step(input bit v, input int b);
    m_commit = 0;
    if (!v) return;
    case (m_st)
      0: if (b == 'hAF) m_st = 1;
      1: begin
        if (b == 'h20) m_st = 2;
        else if (b == 'h6A) begin m_st = 4; m_cnt = 0; end
        else m_st = 0;
      end
      2: begin m_addr = b; m_st = 3; end
      3: begin
        m_st = 0;
        if (m_addr == 'hFF) begin
          if (b == 0) m_lock = 1;
          else if (b == 'hFF) begin
            for (int i = 0; i < N; i++) m_act[i] = m_sh[i];
            m_lock = 0; m_commit = 1;
          end
        end else if (m_addr < N) begin
          m_sh[m_addr] = b;
          if (!m_lock) m_act[m_addr] = b;
        end
      end
      default: begin m_cnt++; if (m_cnt == 7) m_st = 0; end
    endcase
  endtask

  task automatic compare();
    logic [8*N-1:0] exp;
    for (int i = 0; i < N; i++) exp[8*i +: 8] = m_act[i][7:0];
    vecs++;
    if (regs_o !== exp || commit_o !== m_commit || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL %s: regs=%h commit=%b ready=%b expected regs=%h commit=%b ready=1",
               req, regs_o, commit_o, in_ready, exp, m_commit);
    end
  endtask

  task automatic put(input bit v, input int b);
    @(negedge clk);
    compare();
    in_valid = v; in_data = b[7:0];
    model_step(v, b);
  endtask

  task automatic wr(input int a, input int d);
    put(1, 'hAF); put(1, 'h20); put(1, a); put(1, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; model_reset();
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1;
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      bad++; vecs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    req = "R1"; do_reset();
    put(0, 0); put(0, 0);
    // R3: unlocked writes, including the low-first pixel clock pair
    req = "R3"; wr('h05, 'h3C); wr('h1B, 'h34); wr('h1C, 'h12); wr(N-1, 'h81);
    put(0, 0);
    // R2: junk before lead byte
    req = "R2"; put(1, 'h00); put(1, 'h20); put(1, 'h12); wr('h06, 'h77);
    // R9: gaps inside a command
    req = "R9"; put(1, 'hAF); put(0, 'h20); put(1, 'h20); put(0, 'hFF);
    put(1, 'h07); put(0, 'hAF); put(0, 'hFF); put(1, 'h99);
    // R4: lock then staged writes
    req = "R4"; wr('hFF, 'h00); wr('h20, 'h01); wr('h21, 'h02); wr('h22, 'h03);
    wr('h26, 'h04); wr('h05, 'hEE); put(0, 0);
    // R8 while locked: out of range and odd control data
    req = "R8"; wr('h40, 'h55); wr('hFF, 'h12); wr('h27, 'h05);
    // R5: unlock commits
    req = "R5"; wr('hFF, 'hFF); put(0, 0); put(0, 0);
    // R6: copy command carrying lead/opcode-looking operands
    req = "R6"; put(1, 'hAF); put(1, 'h6A); put(1, 'hAF); put(1, 'h20); put(1, 'h05);
    put(1, 'h01); put(1, 'hAF); put(1, 'h20); put(1, 'h05); wr('h08, 'h42);
    // R7: unknown opcode, then an immediate lead byte
    req = "R7"; put(1, 'hAF); put(1, 'h55); put(1, 'hAF); put(1, 'h20); put(1, 'h09); put(1, 'h5A);
    put(1, 'hAF); put(1, 'hAF); put(1, 'h20); put(1, 'h0A); put(1, 'h6B);
    // R5: unlock while already unlocked still pulses
    req = "R5"; wr('hFF, 'hFF); put(0, 0);
    // R8 unlocked
    req = "R8"; wr('hC0, 'h11); wr('hFF, 'h80); wr('h0B, 'h22);
    // mixed random traffic
    req = "R3";
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 5) wr($urandom_range(0, N + 3), $urandom_range(0, 255));
      else if (sel == 5) wr('hFF, 'h00);
      else if (sel == 6) wr('hFF, 'hFF);
      else if (sel == 7) put(0, $urandom_range(0, 255));
      else put(1, $urandom_range(0, 255));
    end
    // R1: reset mid-stream clears everything
    req = "R1"; put(1, 'hAF); put(1, 'h20); do_reset(); put(0, 0);
    wr('h03, 'h66); put(0, 0); put(0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule